// File: doc/BRIEF.md
# I2C Memory Slave Front-End

This block is the serial-bus side of a 256-byte byte-addressed memory that acts as a target on a two-wire I2C bus. A fast system clock oversamples the bus clock and data lines. The block recognises bus Start and Stop conditions and shifts bytes in and out most significant bit first. It answers on the data line through an active-high pull-low enable.

A transaction opens with a select byte. Its upper nibble must be `1010`, the next three bits must equal the strap inputs, and the lowest bit chooses read (1) or write (0). A write carries one address byte followed by data bytes. Each accepted data byte is handed to an external write sequencer as a single-cycle strobe with its address. A Stop placed directly after a data acknowledge asks the sequencer to commit. While the sequencer reports busy, the block stays silent, so a bus master can poll for an acknowledge. Reads fetch bytes from a combinational read port at the current address. A random read is a dummy write of the address followed by a repeated Start with the read bit set.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset the pull-low enable is 0 and neither the byte strobe nor the commit strobe fires.
- R2: The select byte is acknowledged only when bits [7:4] equal 4'b1010 and bits [3:1] equal `chip_sel`. Otherwise the bus is released, and later bytes are not acknowledged until the next Start.
- R3: In a write, the select byte (bit 0 = 0), the address byte and every data byte are acknowledged. Each data byte produces one single-cycle `wr_byte_valid` pulse carrying its address and value.
- R4: Successive data bytes of one write step only the low 4 address bits. These bits wrap from 0xF to 0x0, and the upper bits are kept, so the writes stay on one 16-byte page.
- R5: A Stop that follows directly on the acknowledge slot of an accepted data byte gives exactly one `wr_commit` pulse. A Stop at any other point gives none.
- R6: While `wr_lock` is 1, the select and address bytes are still acknowledged. Data bytes are not acknowledged, raise no `wr_byte_valid` and lead to no commit.
- R7: While `wr_busy` is 1, Start conditions are ignored and nothing is acknowledged, not even a matching select byte. Once busy clears, the same select byte is acknowledged.
- R8: After a select byte with bit 0 = 1, the block sends the byte at the current address, most significant bit first. The address then advances by one (modulo 256) after every byte sent.
- R9: A master that does not acknowledge a read byte ends the read, and the block releases the bus. A later read without an address byte continues at the following address.
- R10: Reads return the same data whatever the value of `wr_lock`.
- R11: The pull-low enable changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_sel | input | 3 | Strap value compared with select bits [3:1] |
| wr_lock | input | 1 | 1 = data bytes refused, memory protected |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 = pull the data line low |
| wr_busy | input | 1 | Write sequencer is running an internal write cycle |
| wr_byte_valid | output | 1 | One-cycle strobe: an accepted data byte |
| wr_byte_addr | output | 8 | Address of the strobed data byte |
| wr_byte_data | output | 8 | Value of the strobed data byte |
| wr_commit | output | 1 | One-cycle strobe: start the internal write cycle |
| rd_addr | output | 8 | Current address presented to the memory read port |
| rd_data | input | 8 | Memory contents at `rd_addr`, combinational |

## Verification
The assertions take several things for granted about the inputs. Outside Start and Stop, the data line moves only while the bus clock is low. Each bus clock phase lasts well beyond the three-cycle synchroniser and edge-detect latency. `wr_busy` rises only after a commit, when the bus is already released. `wr_lock` is steady around each data acknowledge. The bench master holds every quarter bus period for six system clocks and changes data in the middle of the low phase. It switches `wr_lock` only between transactions, and its sequencer model raises busy only in response to `wr_commit`. With that stimulus, every ownership change of the data line falls in a low clock phase, and Start and Stop edges never coincide with a bit edge.

// File: rtl/i2c_mem_pkg.sv
// Shared types and constants of the I2C memory target.
// Assumes one select byte, one address byte and 8-bit data on the bus.
package i2c_mem_pkg;

    localparam int BYTE_W = 8;

    // Fixed upper nibble of the select byte.
    localparam logic [3:0] SEL_FAMILY = 4'b1010;

    // Transaction phase of the byte engine.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEL,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA
    } phase_t;

endpackage

// File: rtl/i2c_pin_sync.sv
// Multi-flop synchroniser for one asynchronous bus line.
// Assumes the line idles high (pull-up), so the chain resets to 1.
module i2c_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/i2c_cond_detect.sv
// Edge and bus-condition detector on the synchronised lines.
// Assumes both inputs already come from synchronisers on clk.
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic scl_d;
    logic sda_d;

    // Keep the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_addr_counter.sv
// Current-address register of the memory target.
// Loads from the address byte. Steps inside a page for writes and
// over the whole space for reads. PAGE_BITS = 0 gives a flat counter.
module i2c_addr_counter #(
    parameter int ADDR_W    = 8,
    parameter int PAGE_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_page,
    input  logic              step_lin,
    output logic [ADDR_W-1:0] cur
);

    logic [ADDR_W-1:0] lin_next;
    logic [ADDR_W-1:0] page_next;

    assign lin_next = cur + ADDR_W'(1);

    generate
        if (PAGE_BITS == 0 || PAGE_BITS >= ADDR_W) begin : g_flat
            assign page_next = lin_next;
        end else begin : g_paged
            assign page_next = {cur[ADDR_W-1:PAGE_BITS],
                                cur[PAGE_BITS-1:0] + PAGE_BITS'(1)};
        end
    endgenerate

    // Update the address: load wins, then read step, then page step.
    always_ff @(posedge clk) begin
        if (!rst_n)         cur <= '0;
        else if (load)      cur <= load_val;
        else if (step_lin)  cur <= lin_next;
        else if (step_page) cur <= page_next;
    end

endmodule

// File: rtl/i2c_mem_target.sv
// I2C target front-end for a byte-addressed memory.
// Oversamples the bus and decodes select, address and data bytes.
// Drives acknowledge and read data as a pull-low enable. Hands written
// bytes and a commit strobe to an external write sequencer.
// Assumes: clk is many times faster than the bus clock, rd_data is
// combinational from rd_addr, and wr_busy rises only after wr_commit.
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PAGE_BITS   = 4,
    parameter int ADDR_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        chip_sel,
    input  logic              wr_lock,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic              wr_busy,
    output logic              wr_byte_valid,
    output logic [ADDR_W-1:0] wr_byte_addr,
    output logic [BYTE_W-1:0] wr_byte_data,
    output logic              wr_commit,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data
);

    localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);
    localparam logic [3:0] END_SLOT = 4'(BYTE_W + 1);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_ev, stop_ev;

    phase_t            phase;
    logic [3:0]        bcnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw, wrote_any, slot10, mack;
    logic [ADDR_W-1:0] cur_addr;
    logic              sel_hit, ld_addr, step_pg, step_ln;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) i_sync_scl (
        .clk(clk), .rst_n(rst_n), .din(scl_in), .dout(scl_s));

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) i_sync_sda (
        .clk(clk), .rst_n(rst_n), .din(sda_in), .dout(sda_s));

    i2c_cond_detect i_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev));

    // Select match: family nibble, strap bits, and no write cycle running.
    assign sel_hit = (shreg[7:4] == SEL_FAMILY) && (shreg[3:1] == chip_sel) && !wr_busy;

    // Address counter controls derived from the byte engine.
    assign ld_addr = (phase == PH_ADDR)  && scl_fall && (bcnt == ACK_SLOT);
    assign step_pg = (phase == PH_WDATA) && scl_fall && (bcnt == ACK_SLOT) && !wr_lock;
    assign step_ln = (phase == PH_RDATA) && scl_rise && (bcnt == ACK_SLOT);

    i2c_addr_counter #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) i_addr (
        .clk(clk), .rst_n(rst_n), .load(ld_addr),
        .load_val(shreg[ADDR_W-1:0]), .step_page(step_pg),
        .step_lin(step_ln), .cur(cur_addr));

    assign rd_addr = cur_addr;

    // Byte engine: bus conditions, bit shifting, acknowledge and read drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase         <= PH_IDLE;
            bcnt          <= '0;
            shreg         <= '0;
            rw            <= 1'b0;
            wrote_any     <= 1'b0;
            slot10        <= 1'b0;
            mack          <= 1'b0;
            sda_pull      <= 1'b0;
            wr_byte_valid <= 1'b0;
            wr_byte_addr  <= '0;
            wr_byte_data  <= '0;
            wr_commit     <= 1'b0;
        end else begin
            wr_byte_valid <= 1'b0;
            wr_commit     <= 1'b0;
            if (start_ev && !wr_busy) begin
                phase     <= PH_SEL;
                bcnt      <= '0;
                sda_pull  <= 1'b0;
                wrote_any <= 1'b0;
                slot10    <= 1'b0;
            end else if (stop_ev) begin
                if (phase == PH_WDATA && slot10 && wrote_any) wr_commit <= 1'b1;
                phase    <= PH_IDLE;
                sda_pull <= 1'b0;
                slot10   <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise) begin
                    if (bcnt < ACK_SLOT && phase != PH_RDATA)
                        shreg <= {shreg[BYTE_W-2:0], sda_s};
                    if (bcnt == ACK_SLOT) mack <= ~sda_s;
                    bcnt <= bcnt + 4'd1;
                end else if (scl_fall) begin
                    slot10 <= 1'b0;
                    if (bcnt == ACK_SLOT) begin
                        case (phase)
                            PH_SEL: begin
                                if (sel_hit) begin
                                    sda_pull <= 1'b1;
                                    rw       <= shreg[0];
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            PH_ADDR: sda_pull <= 1'b1;
                            PH_WDATA: begin
                                if (!wr_lock) begin
                                    sda_pull      <= 1'b1;
                                    wr_byte_valid <= 1'b1;
                                    wr_byte_addr  <= cur_addr;
                                    wr_byte_data  <= shreg;
                                    wrote_any     <= 1'b1;
                                end
                            end
                            default: sda_pull <= 1'b0;
                        endcase
                    end else if (bcnt == END_SLOT) begin
                        bcnt     <= '0;
                        sda_pull <= 1'b0;
                        case (phase)
                            PH_SEL: begin
                                if (rw) begin
                                    phase    <= PH_RDATA;
                                    shreg    <= rd_data;
                                    sda_pull <= ~rd_data[BYTE_W-1];
                                end else begin
                                    phase <= PH_ADDR;
                                end
                            end
                            PH_ADDR:  phase  <= PH_WDATA;
                            PH_WDATA: slot10 <= 1'b1;
                            PH_RDATA: begin
                                if (mack) begin
                                    shreg    <= rd_data;
                                    sda_pull <= ~rd_data[BYTE_W-1];
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end else if (phase == PH_RDATA) begin
                        shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_pull <= ~shreg[BYTE_W-2];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/i2c_mem_target_chk.sv
// Property checker for i2c_mem_target, attached with bind below.
// Assumes the input discipline given in the brief's verification notes.
module i2c_mem_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_pull,
    input logic wr_lock,
    input logic wr_busy,
    input logic wr_byte_valid,
    input logic wr_commit
);

    // R11: the pull enable may only move on an edge that saw the clock low.
    p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !$past(scl_s));

    // R7: no acknowledge of any kind during an internal write cycle.
    p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> !sda_pull);

    // R6: a protected write never reaches the sequencer.
    p_lock_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_lock) |-> !wr_byte_valid);

    // R5: commit is a single-cycle strobe.
    p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R3: each data byte strobes exactly one cycle.
    p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_byte_valid |=> !wr_byte_valid);

    // R5: commit and byte strobe never coincide.
    p_commit_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> !wr_byte_valid);

endmodule

bind i2c_mem_target i2c_mem_target_chk i_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull(sda_pull),
    .wr_lock(wr_lock), .wr_busy(wr_busy),
    .wr_byte_valid(wr_byte_valid), .wr_commit(wr_commit));

// File: tb/test_i2c_mem_target.sv
// Directed bench: a bit-banging bus master plus a memory and write
// sequencer model. Each scenario task checks its own results.
module test_i2c_mem_target;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int BUSY_CYC   = 400;
    localparam logic [7:0] SEL_W = 8'hAA;
    localparam logic [7:0] SEL_R = 8'hAB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] chip_sel = 3'b101;
    logic wr_lock = 1'b0;
    logic sda_pull, wr_busy, wr_byte_valid, wr_commit;
    logic [7:0] wr_byte_addr, wr_byte_data, rd_addr, rd_data;
    logic sda_line;

    logic [7:0] mem [256];
    logic [7:0] pend_a [16];
    logic [7:0] pend_d [16];
    int pend_n, busy_cnt, valid_cnt, commit_cnt, hi_chg;
    int checks = 0, fails = 0;
    logic pull_q, scl_q;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;
    assign rd_data  = mem[rd_addr];
    assign wr_busy  = (busy_cnt != 0);

    i2c_mem_target i_i2c_mem_target (
        .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .wr_lock(wr_lock),
        .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull),
        .wr_busy(wr_busy), .wr_byte_valid(wr_byte_valid),
        .wr_byte_addr(wr_byte_addr), .wr_byte_data(wr_byte_data),
        .wr_commit(wr_commit), .rd_addr(rd_addr), .rd_data(rd_data));

    function automatic logic [7:0] fill(int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    // Memory and write-sequencer model.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= fill(i);
            pend_n <= 0; busy_cnt <= 0; valid_cnt <= 0; commit_cnt <= 0;
        end else begin
            if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
            if (wr_byte_valid) begin
                pend_a[pend_n[3:0]] <= wr_byte_addr;
                pend_d[pend_n[3:0]] <= wr_byte_data;
                pend_n    <= pend_n + 1;
                valid_cnt <= valid_cnt + 1;
            end
            if (wr_commit) begin
                for (int i = 0; i < 16; i++)
                    if (i < pend_n) mem[pend_a[i]] <= pend_d[i];
                pend_n     <= 0;
                commit_cnt <= commit_cnt + 1;
                busy_cnt   <= BUSY_CYC;
            end
        end
    end

    // Monitor: pull enable moving while the bus clock is high (R11).
    always @(posedge clk) begin
        if (!rst_n) hi_chg <= 0;
        else if (scl_m && scl_q && sda_pull != pull_q) hi_chg <= hi_chg + 1;
        pull_q <= sda_pull;
        scl_q  <= scl_m;
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            tick(Q); sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        tick(Q); sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = sda_pull;
        tick(Q); scl_m = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        for (int i = 7; i >= 0; i--) begin
            tick(Q); sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q); scl_m = 1'b0;
        end
        tick(Q); sda_m = ~give_ack; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic wait_ready();
        while (wr_busy) tick(1);
        tick(Q);
    endtask

    // Random read of one byte, checked against exp.
    task automatic read_at(input logic [7:0] a, input logic [7:0] exp, input string tag);
        logic ak;
        logic [7:0] v;
        bus_start(); send_byte(SEL_W, ak); send_byte(a, ak);
        bus_start(); send_byte(SEL_R, ak);
        check({tag, " read select ack"}, ak, 1);
        recv_byte(v, 1'b0);
        check({tag, " read data"}, v, exp);
        bus_stop();
    endtask

    task automatic t_reset();
        check("R1 pull idle", sda_pull, 0);
        check("R1 no byte strobe", valid_cnt, 0);
        check("R1 no commit", commit_cnt, 0);
    endtask

    task automatic t_select_mismatch();
        logic ak;
        bus_start(); send_byte(8'hA6, ak);
        check("R2 wrong strap bits", ak, 0);
        send_byte(SEL_W, ak);
        check("R2 idle until next start", ak, 0);
        bus_stop();
        bus_start(); send_byte(8'hBA, ak);
        check("R2 wrong family nibble", ak, 0);
        bus_stop();
    endtask

    task automatic t_byte_write();
        logic ak;
        int c0 = commit_cnt;
        int v0 = valid_cnt;
        bus_start(); send_byte(SEL_W, ak);
        check("R3 write select ack", ak, 1);
        send_byte(8'h05, ak);
        check("R3 address ack", ak, 1);
        send_byte(8'h3C, ak);
        check("R3 data ack", ak, 1);
        check("R3 one strobe", valid_cnt - v0, 1);
        check("R3 strobe addr", pend_a[0], 8'h05);
        check("R3 strobe data", pend_d[0], 8'h3C);
        bus_stop(); tick(4);
        check("R5 commit after data ack", commit_cnt - c0, 1);
    endtask

    task automatic t_busy_poll();
        logic ak;
        int tries = 0;
        bus_start(); send_byte(SEL_W, ak);
        check("R7 no ack while busy", ak, 0);
        bus_stop();
        do begin
            bus_start(); send_byte(SEL_W, ak); bus_stop();
            tries++;
        end while (!ak && tries < 10);
        check("R7 ack after busy clears", ak, 1);
        check("R7 busy clear at ack", wr_busy, 0);
    endtask

    task automatic t_page_write();
        logic ak;
        logic [7:0] dat [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        logic [7:0] adr [4] = '{8'h1E, 8'h1F, 8'h10, 8'h11};
        int c0;
        wait_ready();
        c0 = commit_cnt;
        bus_start(); send_byte(SEL_W, ak); send_byte(8'h1E, ak);
        for (int i = 0; i < 4; i++) begin
            send_byte(dat[i], ak);
            check("R3 page data ack", ak, 1);
        end
        for (int i = 0; i < 4; i++) check("R4 page wrap address", pend_a[i], adr[i]);
        bus_stop(); tick(4);
        check("R5 page commit", commit_cnt - c0, 1);
        wait_ready();
    endtask

    task automatic t_random_read();
        logic ak;
        logic [7:0] v;
        bus_start(); send_byte(SEL_W, ak); send_byte(8'h1E, ak);
        bus_start(); send_byte(SEL_R, ak);
        check("R8 read select ack", ak, 1);
        recv_byte(v, 1'b1); check("R8 first byte", v, 8'h11);
        recv_byte(v, 1'b1); check("R8 second byte", v, 8'h22);
        recv_byte(v, 1'b0); check("R8 crosses page on read", v, fill(8'h20));
        check("R9 bus released after nack", sda_pull, 0);
        bus_stop();
        bus_start(); send_byte(SEL_R, ak);
        recv_byte(v, 1'b0);
        check("R9 current address continues", v, fill(8'h21));
        bus_stop();
        read_at(8'h10, 8'h33, "R4 wrapped byte stored");
        read_at(8'hFF, fill(8'hFF), "R8 top address");
        bus_start(); send_byte(SEL_R, ak);
        recv_byte(v, 1'b0);
        check("R8 address wraps to zero", v, fill(0));
        bus_stop();
    endtask

    task automatic t_lock();
        logic ak;
        int c0 = commit_cnt;
        int v0 = valid_cnt;
        wr_lock = 1'b1;
        bus_start(); send_byte(SEL_W, ak);
        check("R6 select ack when locked", ak, 1);
        send_byte(8'h05, ak);
        check("R6 address ack when locked", ak, 1);
        send_byte(8'hFF, ak);
        check("R6 data nack when locked", ak, 0);
        bus_stop(); tick(4);
        check("R6 no strobe", valid_cnt - v0, 0);
        check("R6 no commit", commit_cnt - c0, 0);
        read_at(8'h05, 8'h3C, "R10 read under lock");
        wr_lock = 1'b0;
    endtask

    task automatic t_partial_stop();
        logic ak;
        int c0 = commit_cnt;
        bus_start(); send_byte(SEL_W, ak); send_byte(8'h40, ak);
        send_byte(8'h99, ak);
        check("R3 data ack before abort", ak, 1);
        send_bits(8'hA0, 3);
        bus_stop(); tick(4);
        check("R5 mid-byte stop no commit", commit_cnt - c0, 0);
        read_at(8'h40, fill(8'h40), "R5 memory untouched");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        tick(6);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_select_mismatch();
        t_byte_write();
        t_busy_poll();
        t_page_write();
        t_random_read();
        t_lock();
        t_partial_stop();
        check("R11 pull steady while clock high", hi_chg, 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule